// File: doc/BRIEF.md
# Multi-Channel Timer

This block is a register-mapped timer with a parameterised number of counter channels, six by default. Each channel counts ticks taken either from the system clock or from a synchronous pulse input driven by a slow real-time source. A per-channel prescaler sits between the source and the counter. Every channel compares its counter against its own compare value. What happens on a match depends on one of four run modes: stop after one match, restart from zero, flag and carry on, or count freely and never flag.

Software reaches the block through a word-addressed port with separate write and read strobes. Three shared words sit at the bottom of the map: interrupt enable, interrupt status and write-one-to-clear acknowledge. Each channel then has four words: control, clock select, count and compare. The highest channel is twice the data width wide. Its upper count and upper compare words sit just above the last channel. Reading the lower count word captures the upper half, so a two-read sequence returns one coherent 64-bit value. A typical driver disables a channel, pulses the clear bit, programs the source and divider, and then writes the mode and the enable bit in a single access.

Top module: `gpt_timer`

## Requirements
- R1: After reset every register reads zero, every counter is zero and `irq` is all zeros.
- R2: With control bit 0 (enable) set, the system clock selected and divider field d in clock-select bits [7:4], the counter advances once every d+1 clock cycles. With enable clear, the counter holds its value.
- R3: With clock-select bit 0 set, the channel counts rising `rtc_tick` pulses, divided by d+1, instead of clock cycles.
- R4: Writing control bit 1 zeroes the counter and the prescaler in that same write. The bit always reads back as 0, while the enable bit (bit 0) and the mode field (bits [5:4]) read back as written.
- R5: In mode 0 (one-shot), when the counter reaches the compare value it sets the channel's status bit, stops at the compare value and clears its own enable bit.
- R6: In mode 1 (repeat), when the counter reaches the compare value it sets the status bit and the count restarts from zero on that tick.
- R7: In mode 2 (keep-going), when the counter reaches the compare value it sets the status bit and keeps counting upward.
- R8: In mode 3 (free-running), the counter never sets the status bit.
- R9: Status bit n (word 1) stays set until it is acknowledged. `irq[n]` is high only while status bit n and enable bit n of word 0 are both set.
- R10: Writing word 2 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. A match in the same cycle as the acknowledge wins, and the bit stays set.
- R11: The last channel has a 64-bit counter and compare value. Its lower halves sit at its count and compare words (26, 27), and its upper halves at words 28 and 29. Reading word 26 captures the upper count half, and a read of word 28 returns that captured value. A match needs all 64 bits to be equal.
- R12: Channel c (0-based) occupies words 4+4c to 7+4c in the order control, clock select, count, compare. Count and compare are writable, and clock select reads back as divider in [7:4] and source in [0]. Read data appears on `rdata` in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the count source when clock select bit 0 is 0 |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_tick | input | 1 | One-cycle pulses from the slow time base |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| irq | output | 6 | Per-channel interrupt, status AND enable |

## Verification
The bound checker watches, on every cycle, the local counting laws of each channel. A disabled and untouched counter never moves, and an enabled one moves by at most one step. A one-shot match drops the enable bit, a repeat match lands on zero, a free-running channel never raises its status bit, and acknowledge and match interact correctly with the status bit. Only the bench scenarios show the absolute counts, because those depend on the divider, on the tick source and on the compare value chosen. The same holds for the register map, readback and masking of `irq`, the coherent capture of the 64-bit count across a carry into the upper word, and the set-over-clear collision at a precisely timed edge.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

   typedef enum logic [1:0] {
      MODE_ONCE     = 2'b00,
      MODE_RELOAD   = 2'b01,
      MODE_CONTINUE = 2'b10,
      MODE_FREE     = 2'b11
   } gpt_mode_e;

   // shared words
   localparam int unsigned ADR_IEN      = 0;
   localparam int unsigned ADR_STA      = 1;
   localparam int unsigned ADR_ACK      = 2;
   localparam int unsigned CH_BASE      = 4;
   localparam int unsigned WORDS_PER_CH = 4;

   // word offsets inside a channel
   localparam int unsigned OFS_CTL = 0;
   localparam int unsigned OFS_CLK = 1;
   localparam int unsigned OFS_CNT = 2;
   localparam int unsigned OFS_CMP = 3;

   // field positions
   localparam int unsigned CTL_EN_BIT   = 0;
   localparam int unsigned CTL_CLR_BIT  = 1;
   localparam int unsigned CTL_MODE_LSB = 4;
   localparam int unsigned CLK_SRC_BIT  = 0;
   localparam int unsigned CLK_DIV_LSB  = 4;

endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             src_tick,
   input  logic             clr,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   assign tick = run & src_tick & (pre_q == div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (clr) begin
         pre_q <= '0;
      end else if (run && src_tick) begin
         pre_q <= (pre_q == div) ? '0 : pre_q + DIV_W'(1);
      end
   end

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
   import gpt_pkg::*;
#(
   parameter int unsigned CW    = 32,
   parameter int unsigned DW    = 32,
   parameter int unsigned DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rtc_tick,
   input  logic             ctl_we,
   input  logic             clk_we,
   input  logic [1:0]       cnt_we,
   input  logic [1:0]       cmp_we,
   input  logic [DW-1:0]    wdata,
   output logic             en_o,
   output gpt_mode_e        mode_o,
   output logic             src_o,
   output logic [DIV_W-1:0] div_o,
   output logic [CW-1:0]    cnt_o,
   output logic [CW-1:0]    cmp_o,
   output logic             match_o
);

   if (CW != DW && (CW <= DW || CW > 2 * DW)) begin : g_bad_width
      $error("gpt_channel: CW must equal DW or lie in (DW, 2*DW]");
   end

   logic             en_q;
   gpt_mode_e        mode_q;
   logic             src_q;
   logic [DIV_W-1:0] div_q;
   logic [CW-1:0]    cnt_q, cmp_q, cnt_wr, cmp_wr, cnt_inc;
   logic             clr_cmd, src_tick, tick, hit, cnt_load;

   assign clr_cmd  = ctl_we & wdata[CTL_CLR_BIT];
   assign cnt_load = |cnt_we;
   assign src_tick = src_q ? rtc_tick : 1'b1;

   gpt_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (en_q),
      .src_tick (src_tick),
      .clr      (clr_cmd),
      .div      (div_q),
      .tick     (tick)
   );

   // lower/upper word merge for writable count and compare
   if (CW > DW) begin : g_wide
      assign cnt_wr = {cnt_we[1] ? wdata[CW-DW-1:0] : cnt_q[CW-1:DW],
                       cnt_we[0] ? wdata            : cnt_q[DW-1:0]};
      assign cmp_wr = {cmp_we[1] ? wdata[CW-DW-1:0] : cmp_q[CW-1:DW],
                       cmp_we[0] ? wdata            : cmp_q[DW-1:0]};
   end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = cnt_we[1] | cmp_we[1];
      assign cnt_wr    = wdata[CW-1:0];
      assign cmp_wr    = wdata[CW-1:0];
   end

   assign cnt_inc = cnt_q + CW'(1);
   assign hit     = tick & ~clr_cmd & ~cnt_load & (cnt_inc == cmp_q);
   assign match_o = hit & (mode_q != MODE_FREE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mode_q <= MODE_ONCE;
         src_q  <= 1'b0;
         div_q  <= '0;
         cmp_q  <= '0;
      end else begin
         if (ctl_we) begin
            en_q   <= wdata[CTL_EN_BIT];
            mode_q <= gpt_mode_e'(wdata[CTL_MODE_LSB +: 2]);
         end else if (match_o && mode_q == MODE_ONCE) begin
            en_q <= 1'b0;
         end
         if (clk_we) begin
            src_q <= wdata[CLK_SRC_BIT];
            div_q <= wdata[CLK_DIV_LSB +: DIV_W];
         end
         if (|cmp_we) cmp_q <= cmp_wr;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_cmd) begin
         cnt_q <= '0;
      end else if (cnt_load) begin
         cnt_q <= cnt_wr;
      end else if (tick) begin
         if (mode_q == MODE_RELOAD && hit) cnt_q <= '0;
         else                              cnt_q <= cnt_inc;
      end
   end

   assign en_o   = en_q;
   assign mode_o = mode_q;
   assign src_o  = src_q;
   assign div_o  = div_q;
   assign cnt_o  = cnt_q;
   assign cmp_o  = cmp_q;

endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
   import gpt_pkg::*;
#(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DIV_W  = 4,
   localparam int unsigned WIDE_W    = 2 * DATA_W,
   localparam int unsigned LAST      = NUM_CH - 1,
   localparam int unsigned HI_CNT    = CH_BASE + WORDS_PER_CH * NUM_CH,
   localparam int unsigned HI_CMP    = HI_CNT + 1,
   localparam int unsigned NUM_WORDS = HI_CMP + 1,
   localparam int unsigned ADDR_W    = $clog2(NUM_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtc_tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] irq
);

   if (NUM_CH < 2 || NUM_CH > DATA_W) begin : g_bad_nch
      $error("gpt_timer: NUM_CH must lie in [2, DATA_W]");
   end
   if (DATA_W < 8 || DIV_W + CLK_DIV_LSB > DATA_W) begin : g_bad_dw
      $error("gpt_timer: DATA_W too small for the clock-select field");
   end

   logic [NUM_CH-1:0] ien_q, sta_q;
   logic [NUM_CH-1:0] ch_en, ch_match, ch_wr;
   logic [1:0]        ch_mode [NUM_CH];
   logic [WIDE_W-1:0] ch_cnt  [NUM_CH];
   logic [WIDE_W-1:0] ch_cmp  [NUM_CH];
   logic [DATA_W-1:0] ctl_rd  [NUM_CH];
   logic [DATA_W-1:0] clk_rd  [NUM_CH];
   logic [DATA_W-1:0] hi_latch_q, rd_mux;
   logic              ack_we;

   assign ack_we = wr_en && (addr == ADDR_W'(ADR_ACK));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int unsigned W = (c == LAST) ? WIDE_W : DATA_W;
      localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CH_BASE + WORDS_PER_CH * c);

      logic             ctl_we, clk_we;
      logic [1:0]       cnt_we, cmp_we;
      logic             en_w, src_w, match_w;
      gpt_mode_e        mode_w;
      logic [DIV_W-1:0] div_w;
      logic [W-1:0]     cnt_w, cmp_w;

      assign ctl_we    = wr_en && addr == A_BASE + ADDR_W'(OFS_CTL);
      assign clk_we    = wr_en && addr == A_BASE + ADDR_W'(OFS_CLK);
      assign cnt_we[0] = wr_en && addr == A_BASE + ADDR_W'(OFS_CNT);
      assign cmp_we[0] = wr_en && addr == A_BASE + ADDR_W'(OFS_CMP);
      if (c == LAST) begin : g_hi
         assign cnt_we[1] = wr_en && addr == ADDR_W'(HI_CNT);
         assign cmp_we[1] = wr_en && addr == ADDR_W'(HI_CMP);
      end else begin : g_no_hi
         assign cnt_we[1] = 1'b0;
         assign cmp_we[1] = 1'b0;
      end

      gpt_channel #(.CW(W), .DW(DATA_W), .DIV_W(DIV_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .rtc_tick (rtc_tick),
         .ctl_we   (ctl_we),
         .clk_we   (clk_we),
         .cnt_we   (cnt_we),
         .cmp_we   (cmp_we),
         .wdata    (wdata),
         .en_o     (en_w),
         .mode_o   (mode_w),
         .src_o    (src_w),
         .div_o    (div_w),
         .cnt_o    (cnt_w),
         .cmp_o    (cmp_w),
         .match_o  (match_w)
      );

      assign ch_en[c]    = en_w;
      assign ch_match[c] = match_w;
      assign ch_wr[c]    = ctl_we | (|cnt_we);
      assign ch_mode[c]  = mode_w;
      assign ch_cnt[c]   = WIDE_W'(cnt_w);
      assign ch_cmp[c]   = WIDE_W'(cmp_w);
      assign ctl_rd[c]   = DATA_W'({mode_w, 3'b000, en_w});
      assign clk_rd[c]   = DATA_W'({div_w, 3'b000, src_w});
   end

   // shared interrupt words
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_q <= '0;
         sta_q <= '0;
      end else begin
         if (wr_en && addr == ADDR_W'(ADR_IEN)) ien_q <= wdata[NUM_CH-1:0];
         sta_q <= (sta_q & ~(ack_we ? wdata[NUM_CH-1:0] : '0)) | ch_match;
      end
   end

   assign irq = sta_q & ien_q;

   // read path
   always_comb begin
      rd_mux = '0;
      if (addr == ADDR_W'(ADR_IEN)) rd_mux = DATA_W'(ien_q);
      if (addr == ADDR_W'(ADR_STA)) rd_mux = DATA_W'(sta_q);
      if (addr == ADDR_W'(HI_CNT))  rd_mux = hi_latch_q;
      if (addr == ADDR_W'(HI_CMP))  rd_mux = ch_cmp[LAST][WIDE_W-1:DATA_W];
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADDR_W'(CH_BASE + WORDS_PER_CH * c + OFS_CTL)) rd_mux = ctl_rd[c];
         if (addr == ADDR_W'(CH_BASE + WORDS_PER_CH * c + OFS_CLK)) rd_mux = clk_rd[c];
         if (addr == ADDR_W'(CH_BASE + WORDS_PER_CH * c + OFS_CNT)) rd_mux = ch_cnt[c][DATA_W-1:0];
         if (addr == ADDR_W'(CH_BASE + WORDS_PER_CH * c + OFS_CMP)) rd_mux = ch_cmp[c][DATA_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata      <= '0;
         hi_latch_q <= '0;
      end else if (rd_en) begin
         rdata <= rd_mux;
         if (addr == ADDR_W'(CH_BASE + WORDS_PER_CH * LAST + OFS_CNT))
            hi_latch_q <= ch_cnt[LAST][WIDE_W-1:DATA_W];
      end
   end

endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   localparam int unsigned WIDE_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic [NUM_CH-1:0] sta_q,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] ch_match,
   input logic [NUM_CH-1:0] ch_wr,
   input logic [1:0]        ch_mode [NUM_CH],
   input logic [WIDE_W-1:0] ch_cnt  [NUM_CH]
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R2
      hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_en[c] && !ch_wr[c]) |=> $stable(ch_cnt[c]));

      // R2
      single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_en[c] && !ch_wr[c] && !ch_match[c]) |=>
            (ch_cnt[c] == $past(ch_cnt[c]) || ch_cnt[c] == $past(ch_cnt[c]) + WIDE_W'(1)
             || ch_cnt[c] == '0));

      // R5
      once_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_match[c] && ch_mode[c] == 2'b00 && !ch_wr[c]) |=> !ch_en[c]);

      // R6
      reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_match[c] && ch_mode[c] == 2'b01) |=> ch_cnt[c] == '0);

      // R8
      free_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_mode[c] == 2'b11 && !sta_q[c]) |=> !sta_q[c]);

      // R10
      ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && addr == ADDR_W'(2) && wdata[c] && !ch_match[c]) |=> !sta_q[c]);

      // R10
      match_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_match[c] |=> sta_q[c]);
   end

endmodule

bind gpt_timer gpt_timer_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .sta_q    (sta_q),
   .ch_en    (ch_en),
   .ch_match (ch_match),
   .ch_wr    (ch_wr),
   .ch_mode  (ch_mode),
   .ch_cnt   (ch_cnt)
);

// File: tb/gpt_timer_tb.sv
`timescale 1ns/1ps
module gpt_timer_tb;

   localparam int A_IEN = 0, A_STA = 1, A_ACK = 2, A_HI_CNT = 28, A_HI_CMP = 29;

   logic        clk = 1'b0, rst_n = 1'b0, rtc_tick = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0, rdata, d, first;
   logic [5:0]  irq;
   int n_tests = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpt_timer u_dut (
      .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   typedef struct packed {
      logic [2:0]  ch;
      logic [1:0]  mode;
      logic [3:0]  div;
      logic [31:0] cmp;
      logic [15:0] idle;
      logic [31:0] exp_cnt;
      logic        exp_sta;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'd0, 4'd0, 32'd10,  16'd5,  32'd5,  1'b0},  // R5 before the match
      '{3'd1, 2'd0, 4'd0, 32'd10,  16'd20, 32'd10, 1'b1},  // R5 stops at compare
      '{3'd2, 2'd1, 4'd0, 32'd8,   16'd20, 32'd4,  1'b1},  // R6 20 mod 8
      '{3'd3, 2'd2, 4'd0, 32'd6,   16'd15, 32'd15, 1'b1},  // R7 passes compare
      '{3'd4, 2'd3, 4'd0, 32'd6,   16'd15, 32'd15, 1'b0},  // R8 no flag
      '{3'd0, 2'd3, 4'd3, 32'd100, 16'd14, 32'd3,  1'b0},  // R2 divide by 4
      '{3'd2, 2'd1, 4'd1, 32'd5,   16'd23, 32'd1,  1'b1},  // R6 with divide by 2
      '{3'd1, 2'd2, 4'd2, 32'd3,   16'd6,  32'd2,  1'b0}   // R7 divide by 3, not yet
   };

   task automatic bus_wr(input int a, input logic [31:0] v);
      addr = 5'(a); wdata = v; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input int a, output logic [31:0] v);
      addr = 5'(a); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int base(input int c);
      return 4 + 4 * c;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 0);
      bus_rd(A_IEN, d);      chk("R1 ien", d, 0);
      bus_rd(A_STA, d);      chk("R1 sta", d, 0);
      bus_rd(base(2), d);    chk("R1 ctl2", d, 0);
      bus_rd(base(5) + 2, d); chk("R1 cnt5", d, 0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         int   b;
         v = VECS[i];
         b = base(int'(v.ch));
         bus_wr(b, 0);
         bus_wr(b, 32'h2);
         bus_wr(b + 1, 32'(v.div) << 4);
         bus_wr(b + 3, v.cmp);
         bus_wr(A_ACK, 32'h3f);
         bus_wr(b, (32'(v.mode) << 4) | 32'h1);
         repeat (int'(v.idle)) @(negedge clk);
         bus_rd(b + 2, d); chk($sformatf("R2/R5-R8 vec%0d cnt", i), d, v.exp_cnt);
         bus_rd(A_STA, d); chk($sformatf("R5-R8 vec%0d sta", i), 32'(d[v.ch]), 32'(v.exp_sta));
      end

      for (int c = 0; c < 6; c++) bus_wr(base(c), 0);
      bus_wr(A_ACK, 32'h3f);

      // R12 readback of clock select and compare
      bus_wr(base(4) + 1, 32'h51);
      bus_wr(base(4) + 3, 32'hA5A5);
      bus_rd(base(4) + 1, d); chk("R12 clk readback", d, 32'h51);
      bus_rd(base(4) + 3, d); chk("R12 cmp readback", d, 32'hA5A5);

      // R4 clear command
      bus_wr(base(0) + 1, 0);
      bus_wr(base(0), 32'h31);
      repeat (10) @(negedge clk);
      bus_wr(base(0), 32'h33);
      bus_rd(base(0) + 2, d); chk("R4 cnt after clear", d, 0);
      bus_rd(base(0), d);     chk("R4 clear bit reads 0", d, 32'h31);

      // R2 hold while disabled
      bus_wr(base(0), 32'h30);
      bus_rd(base(0) + 2, first);
      repeat (10) @(negedge clk);
      bus_rd(base(0) + 2, d); chk("R2 hold when disabled", d, first);

      // R3 rtc source
      bus_wr(base(3), 0);
      bus_wr(base(3), 32'h2);
      bus_wr(base(3) + 1, 32'h1);
      bus_wr(base(3) + 3, 32'hFFFF);
      bus_wr(base(3), 32'h31);
      for (int p = 0; p < 5; p++) begin
         rtc_tick = 1'b1; @(negedge clk);
         rtc_tick = 1'b0; repeat (2) @(negedge clk);
      end
      bus_rd(base(3) + 2, d); chk("R3 rtc pulses counted", d, 5);
      repeat (20) @(negedge clk);
      bus_rd(base(3) + 2, d); chk("R3 clock cycles ignored", d, 5);
      bus_wr(base(3), 0);
      bus_wr(base(3), 32'h2);
      bus_wr(base(3) + 1, 32'h11);
      bus_wr(base(3), 32'h31);
      for (int p = 0; p < 6; p++) begin
         rtc_tick = 1'b1; @(negedge clk);
         rtc_tick = 1'b0; repeat (2) @(negedge clk);
      end
      bus_rd(base(3) + 2, d); chk("R3 rtc divided by 2", d, 3);
      bus_wr(base(3), 0);

      // R9 interrupt masking, R5 one-shot stop
      bus_wr(A_IEN, 32'h1);
      bus_wr(A_ACK, 32'h3f);
      for (int c = 0; c < 2; c++) begin
         bus_wr(base(c) + 1, 0);
         bus_wr(base(c) + 3, 3);
         bus_wr(base(c), 32'h2);
         bus_wr(base(c), 32'h1);
      end
      repeat (10) @(negedge clk);
      chk("R9 irq masked by enable", 32'(irq), 32'h1);
      bus_rd(A_STA, d);       chk("R9 both status bits", d, 32'h3);
      bus_rd(base(0), d);     chk("R5 enable self-cleared", d, 0);
      bus_rd(base(0) + 2, d); chk("R5 held at compare", d, 3);

      // R10 acknowledge
      bus_wr(A_ACK, 0);
      bus_rd(A_STA, d);       chk("R10 zero ack no effect", d, 32'h3);
      bus_wr(A_ACK, 32'h2);
      bus_rd(A_STA, d);       chk("R10 ack bit 1", d, 32'h1);
      chk("R10 irq0 still high", 32'(irq), 32'h1);
      bus_wr(A_ACK, 32'h1);
      chk("R10 irq cleared", 32'(irq), 0);

      // R10 match wins over a same-cycle acknowledge
      bus_wr(base(0), 0);
      bus_wr(base(0) + 3, 2);
      bus_wr(A_ACK, 32'h3f);
      bus_wr(base(0), 32'h13);
      @(negedge clk);
      bus_wr(A_ACK, 32'h1);
      bus_rd(A_STA, d);       chk("R10 match beats ack", 32'(d[0]), 1);
      bus_wr(base(0), 0);
      bus_wr(A_ACK, 32'h3f);

      // R11 coherent 64-bit read across a carry
      bus_wr(base(5) + 1, 0);
      bus_wr(base(5) + 2, 32'hFFFF_FFF5);
      bus_wr(A_HI_CNT, 0);
      bus_wr(base(5) + 3, 0);
      bus_wr(A_HI_CMP, 5);
      bus_wr(base(5), 32'h31);
      bus_rd(base(5) + 2, d); chk("R11 low before carry", d, 32'hFFFF_FFF5);
      repeat (20) @(negedge clk);
      bus_rd(A_HI_CNT, d);    chk("R11 high word captured", d, 0);
      bus_rd(base(5) + 2, d); chk("R11 low after carry", d, 32'hB);
      bus_rd(A_HI_CNT, d);    chk("R11 high after carry", d, 1);
      bus_rd(A_HI_CMP, d);    chk("R11 upper compare readback", d, 5);

      // R11 match needs all 64 bits
      bus_wr(base(5), 0);
      bus_wr(base(5) + 2, 32'hFFFF_FFFE);
      bus_wr(A_HI_CNT, 0);
      bus_wr(base(5) + 3, 1);
      bus_wr(A_HI_CMP, 2);
      bus_wr(A_ACK, 32'h3f);
      bus_wr(base(5), 32'h21);
      repeat (6) @(negedge clk);
      bus_rd(A_STA, d);       chk("R11 upper half mismatch", 32'(d[5]), 0);
      bus_wr(base(5), 0);
      bus_wr(base(5) + 2, 32'hFFFF_FFFE);
      bus_wr(A_HI_CNT, 0);
      bus_wr(A_HI_CMP, 1);
      bus_wr(A_ACK, 32'h3f);
      bus_wr(base(5), 32'h21);
      repeat (6) @(negedge clk);
      bus_rd(A_STA, d);       chk("R11 full 64-bit match", 32'(d[5]), 1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule